// File: doc/BRIEF.md
# Synchronous Multiplexed Host Bus Target

This block is the device-side end of a synchronous parallel host bus. Address and data share one 16-bit group of lines. The host opens an access by pulling chip select low, marks the address with an active-low address-valid strobe, inserts one wait state, and then moves data in 16-bit beats. The bus clock runs at a quarter of the host's rate and toggles only while an access is in progress. The block runs on its own system clock. It detects rising edges of the sampled bus clock and steps a phase machine on each one.

Each 32-bit word crosses the bus as two beats, low half first. A write ends in one strobe on a simple internal register port that carries the whole word. A read raises a request on that port as soon as the address is latched. The returned word is then driven back one half per beat. The shared lines are driven only while the host is reading with its output enable low. If chip select rises early, the access is dropped and no internal write is issued.

Top module: `msync_bus_slave`

## Requirements
- R1: After reset the data enable `bus_ad_oe` is low and neither `reg_wr_req` nor `reg_rd_req` pulses until an access starts.
- R2: An access starts on a bus clock rising edge that sees `bus_cs_n` and `bus_adv_n` both low. The address lines at that edge are latched as a word address: `reg_addr` = bits 15:1, and bit 0 is ignored.
- R3: A write (`bus_rw` = 0 at the address edge) takes the beat on the second edge after the address edge as bits 15:0 and the beat on the third edge as bits 31:16. It then pulses `reg_wr_req` for exactly one clock, with `reg_wr_data` holding the full word.
- R4: A read (`bus_rw` = 1 at the address edge) pulses `reg_rd_req` for one clock, in the clock after the address edge, once per read.
- R5: During a read, the word returned with `reg_rd_valid` is driven on `bus_ad_out`. Bits 15:0 are present before the edge that samples the first beat, and bits 31:16 before the edge that samples the second.
- R6: `bus_ad_oe` is high only while `bus_cs_n` and `bus_oe_n` are low, the access in progress is a read, and that access is not finished. It falls in the same clock that `bus_cs_n` rises. It is never high during a write.
- R7: If `bus_cs_n` rises before the final beat, the block returns to idle without pulsing `reg_wr_req`, and the next access completes normally.
- R8: Every access finishes within WAIT_STATES + BEATS + 1 bus clock edges of its address edge, far inside the host's 128-bus-clock timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_clk | input | 1 | Host bus clock, sampled |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_adv_n | input | 1 | Address-valid strobe, active low |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_oe_n | input | 1 | Host output enable, active low |
| bus_ad_in | input | 16 | Shared address/data lines, input side |
| bus_ad_out | output | 16 | Shared lines, driven value |
| bus_ad_oe | output | 1 | Tristate enable for the shared lines |
| reg_addr | output | 15 | Word address of the current access |
| reg_wr_req | output | 1 | One-clock internal write strobe |
| reg_wr_data | output | 32 | Assembled write word |
| reg_rd_req | output | 1 | One-clock internal read request |
| reg_rd_data | input | 32 | Read word from the register port |
| reg_rd_valid | input | 1 | Qualifies `reg_rd_data` |

## Verification
Writes use data words whose two halves differ, so a swapped beat order or a beat dropped into the wrong half shows up in the assembled word. Odd and even addresses for the same word confirm that bit 0 is discarded. Reads return address-derived words, and the bench samples each beat just before the edge that would take it. This separates correct half ordering from late or stale data, and it also checks the enable level during the wait state and at chip-select release. Writes and reads are each cut short after one beat. Each abort is followed by a clean access, which shows that no strobe leaks out and that the phase machine is back in idle.

// File: rtl/msb_pkg.sv
`timescale 1ns/1ps
package msb_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_DATA = 2'd2
  } phase_t;

  // Index width for a count that may be 1.
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/msb_edge_det.sv
`timescale 1ns/1ps
module msb_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic rise
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_in;
  end

  assign rise = level_in & ~level_q;
endmodule

// File: rtl/msb_phase_fsm.sv
`timescale 1ns/1ps
module msb_phase_fsm
  import msb_pkg::*;
#(
  parameter int WAIT_STATES = 1,
  parameter int BEATS       = 2,
  localparam int WCNT_W     = idx_width(WAIT_STATES + 1),
  localparam int BIDX_W     = idx_width(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              cs_n,
  input  logic              adv_n,
  input  logic              rw,
  output phase_t            phase,
  output logic [BIDX_W-1:0] beat_idx,
  output logic              is_read,
  output logic              start_evt,
  output logic              beat_evt,
  output logic              last_evt,
  output logic              abort_evt
);
  logic [WCNT_W-1:0] wcnt;

  assign start_evt = rise & ~cs_n & ~adv_n & (phase == PH_IDLE);
  assign beat_evt  = rise & ~cs_n & (phase == PH_DATA);
  assign last_evt  = beat_evt & (beat_idx == BIDX_W'(BEATS - 1));
  assign abort_evt = cs_n & (phase != PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      wcnt     <= '0;
      beat_idx <= '0;
      is_read  <= 1'b0;
    end else if (cs_n) begin
      phase    <= PH_IDLE;
      wcnt     <= '0;
      beat_idx <= '0;
    end else if (rise) begin
      unique case (phase)
        PH_IDLE: if (!adv_n) begin
          phase   <= PH_WAIT;
          wcnt    <= '0;
          is_read <= rw;
        end
        PH_WAIT: begin
          if (wcnt == WCNT_W'(WAIT_STATES - 1)) phase <= PH_DATA;
          else                                  wcnt  <= wcnt + 1'b1;
        end
        PH_DATA: begin
          if (beat_idx == BIDX_W'(BEATS - 1)) begin
            phase    <= PH_IDLE;
            beat_idx <= '0;
          end else begin
            beat_idx <= beat_idx + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/msb_wr_assembler.sv
`timescale 1ns/1ps
module msb_wr_assembler
  import msb_pkg::*;
#(
  parameter int BEAT_W  = 16,
  parameter int BEATS   = 2,
  localparam int WORD_W = BEAT_W * BEATS,
  localparam int BIDX_W = idx_width(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_evt,
  input  logic              last_evt,
  input  logic              is_read,
  input  logic [BIDX_W-1:0] beat_idx,
  input  logic [BEAT_W-1:0] ad_in,
  output logic              wr_req,
  output logic [WORD_W-1:0] wr_data
);
  for (genvar g = 0; g < BEATS; g++) begin : g_lane
    logic [BEAT_W-1:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q <= '0;
      else if (beat_evt && !is_read && beat_idx == BIDX_W'(g)) lane_q <= ad_in;
    end
    assign wr_data[g*BEAT_W +: BEAT_W] = lane_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_req <= 1'b0;
    else        wr_req <= last_evt & ~is_read;
  end
endmodule

// File: rtl/msb_rd_buffer.sv
`timescale 1ns/1ps
module msb_rd_buffer
  import msb_pkg::*;
#(
  parameter int BEAT_W  = 16,
  parameter int BEATS   = 2,
  localparam int WORD_W = BEAT_W * BEATS,
  localparam int BIDX_W = idx_width(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_rd,
  input  logic              rd_valid,
  input  logic [WORD_W-1:0] rd_data,
  input  logic [BIDX_W-1:0] beat_idx,
  output logic              rd_req,
  output logic [BEAT_W-1:0] ad_out
);
  logic [WORD_W-1:0] word_q;
  logic              pend_q;
  logic [BEAT_W-1:0] slice [BEATS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_req <= 1'b0;
      pend_q <= 1'b0;
      word_q <= '0;
    end else begin
      rd_req <= start_rd;
      if (start_rd) begin
        pend_q <= 1'b1;
      end else if (rd_valid && pend_q) begin
        pend_q <= 1'b0;
        word_q <= rd_data;
      end
    end
  end

  for (genvar g = 0; g < BEATS; g++) begin : g_slice
    assign slice[g] = word_q[g*BEAT_W +: BEAT_W];
  end

  assign ad_out = slice[beat_idx];
endmodule

// File: rtl/msync_bus_slave.sv
`timescale 1ns/1ps
module msync_bus_slave
  import msb_pkg::*;
#(
  parameter int BEAT_W       = 16,
  parameter int BEATS        = 2,
  parameter int WAIT_STATES  = 1,
  parameter int TIMEOUT_BCLK = 128,
  localparam int WORD_W      = BEAT_W * BEATS,
  localparam int WADDR_W     = BEAT_W - 1,
  localparam int BIDX_W      = idx_width(BEATS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_clk,
  input  logic               bus_cs_n,
  input  logic               bus_adv_n,
  input  logic               bus_rw,
  input  logic               bus_oe_n,
  input  logic [BEAT_W-1:0]  bus_ad_in,
  output logic [BEAT_W-1:0]  bus_ad_out,
  output logic               bus_ad_oe,
  output logic [WADDR_W-1:0] reg_addr,
  output logic               reg_wr_req,
  output logic [WORD_W-1:0]  reg_wr_data,
  output logic               reg_rd_req,
  input  logic [WORD_W-1:0]  reg_rd_data,
  input  logic               reg_rd_valid
);
  // Drop the byte bit: the port is word addressed.
  function automatic logic [WADDR_W-1:0] word_addr(input logic [BEAT_W-1:0] a);
    return a[BEAT_W-1:1];
  endfunction

  phase_t            phase;
  logic [BIDX_W-1:0] beat_idx;
  logic              is_read;
  logic              rise;
  logic              start_evt, beat_evt, last_evt, abort_evt;
  logic              busy;
  logic              start_rd;

  msb_edge_det u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .level_in (bus_clk),
    .rise     (rise)
  );

  msb_phase_fsm #(.WAIT_STATES(WAIT_STATES), .BEATS(BEATS)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise      (rise),
    .cs_n      (bus_cs_n),
    .adv_n     (bus_adv_n),
    .rw        (bus_rw),
    .phase     (phase),
    .beat_idx  (beat_idx),
    .is_read   (is_read),
    .start_evt (start_evt),
    .beat_evt  (beat_evt),
    .last_evt  (last_evt),
    .abort_evt (abort_evt)
  );

  msb_wr_assembler #(.BEAT_W(BEAT_W), .BEATS(BEATS)) u_wr (
    .clk      (clk),
    .rst_n    (rst_n),
    .beat_evt (beat_evt),
    .last_evt (last_evt),
    .is_read  (is_read),
    .beat_idx (beat_idx),
    .ad_in    (bus_ad_in),
    .wr_req   (reg_wr_req),
    .wr_data  (reg_wr_data)
  );

  assign start_rd = start_evt & bus_rw;

  msb_rd_buffer #(.BEAT_W(BEAT_W), .BEATS(BEATS)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_rd (start_rd),
    .rd_valid (reg_rd_valid),
    .rd_data  (reg_rd_data),
    .beat_idx (beat_idx),
    .rd_req   (reg_rd_req),
    .ad_out   (bus_ad_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reg_addr <= '0;
    else if (start_evt) reg_addr <= word_addr(bus_ad_in);
  end

  assign busy      = (phase != PH_IDLE);
  assign bus_ad_oe = ~bus_cs_n & ~bus_oe_n & is_read & busy;
endmodule

// File: rtl/msb_checker.sv
`timescale 1ns/1ps
module msb_checker #(
  parameter int LIMIT = 128
) (
  input logic clk,
  input logic rst_n,
  input logic bus_cs_n,
  input logic bus_adv_n,
  input logic bus_oe_n,
  input logic bus_rw,
  input logic bus_ad_oe,
  input logic reg_wr_req,
  input logic reg_rd_req,
  input logic rise,
  input logic start_evt,
  input logic last_evt,
  input logic abort_evt,
  input logic is_read,
  input logic busy
);
  localparam int CW = $clog2(LIMIT + 1) + 1;
  logic [CW-1:0] busy_edges;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     busy_edges <= '0;
    else if (!busy) busy_edges <= '0;
    else if (rise)  busy_edges <= busy_edges + 1'b1;
  end

  a_r2_start_needs_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> (!bus_cs_n && !bus_adv_n));
  a_r3_single_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_req |=> !reg_wr_req);
  a_r3_wr_after_last_beat: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_req |-> $past(last_evt));
  a_r4_rdreq_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && bus_rw) |=> reg_rd_req);
  a_r4_rdreq_only_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_req |-> $past(start_evt));
  a_r6_oe_gated: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ad_oe |-> (!bus_cs_n && !bus_oe_n && is_read));
  a_r7_cs_high_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cs_n |=> !busy);
  a_r7_abort_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> !reg_wr_req);
  a_r8_within_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    busy_edges < CW'(LIMIT));
endmodule

bind msync_bus_slave msb_checker #(.LIMIT(TIMEOUT_BCLK)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_cs_n   (bus_cs_n),
  .bus_adv_n  (bus_adv_n),
  .bus_oe_n   (bus_oe_n),
  .bus_rw     (bus_rw),
  .bus_ad_oe  (bus_ad_oe),
  .reg_wr_req (reg_wr_req),
  .reg_rd_req (reg_rd_req),
  .rise       (rise),
  .start_evt  (start_evt),
  .last_evt   (last_evt),
  .abort_evt  (abort_evt),
  .is_read    (is_read),
  .busy       (busy)
);

// File: tb/msync_bus_slave_tb.sv
`timescale 1ns/1ps
module msync_bus_slave_tb;
  localparam int RD_LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_clk = 1'b0, bus_cs_n = 1'b1, bus_adv_n = 1'b1;
  logic        bus_rw = 1'b0, bus_oe_n = 1'b1;
  logic [15:0] bus_ad_in = '0;
  logic [15:0] bus_ad_out;
  logic        bus_ad_oe;
  logic [14:0] reg_addr;
  logic        reg_wr_req, reg_rd_req;
  logic [31:0] reg_wr_data;
  logic [31:0] reg_rd_data = '0;
  logic        reg_rd_valid = 1'b0;

  int vectors = 0, fails = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [14:0] last_wr_addr, last_rd_addr;
  logic [31:0] last_wr_data;
  bit done = 0;

  always #2.5 clk = ~clk;

  msync_bus_slave u_dut (
    .clk, .rst_n, .bus_clk, .bus_cs_n, .bus_adv_n, .bus_rw, .bus_oe_n,
    .bus_ad_in, .bus_ad_out, .bus_ad_oe, .reg_addr, .reg_wr_req,
    .reg_wr_data, .reg_rd_req, .reg_rd_data, .reg_rd_valid
  );

  function automatic logic [31:0] model_word(input logic [14:0] a);
    return {16'hC3A0 ^ {1'b0, a}, 16'h0F0F ^ {a, 1'b1}};
  endfunction

  // Register-port responder and strobe monitor.
  initial begin
    int cd = 0;
    forever begin
      @(negedge clk);
      reg_rd_valid = 1'b0;
      if (cd > 0) begin
        cd--;
        if (cd == 0) begin
          reg_rd_valid = 1'b1;
          reg_rd_data  = model_word(last_rd_addr);
        end
      end
      if (reg_rd_req) begin
        rd_cnt++;
        last_rd_addr = reg_addr;
        cd = RD_LAT;
      end
      if (reg_wr_req) begin
        wr_cnt++;
        last_wr_addr = reg_addr;
        last_wr_data = reg_wr_data;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One bus clock: outputs are sampled just before the rising edge.
  task automatic bus_tick(output logic [15:0] s_ad, output logic s_oe);
    @(negedge clk);
    @(negedge clk);
    s_ad = bus_ad_out;
    s_oe = bus_ad_oe;
    bus_clk = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_clk = 1'b0;
  endtask

  task automatic do_write(input logic [15:0] addr, input logic [31:0] data);
    logic [15:0] s; logic o; int w0;
    w0 = wr_cnt;
    bus_cs_n = 0; bus_adv_n = 0; bus_rw = 0; bus_oe_n = 1; bus_ad_in = addr;
    bus_tick(s, o);
    bus_adv_n = 1; bus_ad_in = 16'hDEAD;
    bus_tick(s, o);
    bus_ad_in = data[15:0];
    bus_tick(s, o);
    chk("R6 no drive during write", {31'd0, o}, 32'd0);
    bus_ad_in = data[31:16];
    bus_tick(s, o);
    chk("R8 write done by last beat", wr_cnt, w0 + 1);
    bus_cs_n = 1;
    bus_tick(s, o);
    chk("R3 single write strobe", wr_cnt, w0 + 1);
    chk("R3 write data order", last_wr_data, data);
    chk("R2 word address", {17'd0, last_wr_addr}, {17'd0, addr[15:1]});
  endtask

  task automatic do_read(input logic [15:0] addr);
    logic [15:0] s; logic o; int r0; logic [31:0] exp;
    r0 = rd_cnt;
    exp = model_word(addr[15:1]);
    bus_cs_n = 0; bus_adv_n = 0; bus_rw = 1; bus_oe_n = 1; bus_ad_in = addr;
    bus_tick(s, o);
    chk("R6 idle no drive", {31'd0, o}, 32'd0);
    bus_adv_n = 1; bus_oe_n = 0;
    bus_tick(s, o);
    chk("R6 drive in wait state", {31'd0, o}, 32'd1);
    bus_tick(s, o);
    chk("R5 low half beat", {16'd0, s}, {16'd0, exp[15:0]});
    bus_tick(s, o);
    chk("R5 high half beat", {16'd0, s}, {16'd0, exp[31:16]});
    chk("R6 drive on last beat", {31'd0, o}, 32'd1);
    bus_cs_n = 1; bus_oe_n = 1;
    #1;
    chk("R6 release on cs high", {31'd0, bus_ad_oe}, 32'd0);
    bus_tick(s, o);
    chk("R4 one read request", rd_cnt, r0 + 1);
    chk("R2 read word address", {17'd0, last_rd_addr}, {17'd0, addr[15:1]});
  endtask

  task automatic do_abort_write(input logic [15:0] addr);
    logic [15:0] s; logic o; int w0;
    w0 = wr_cnt;
    bus_cs_n = 0; bus_adv_n = 0; bus_rw = 0; bus_oe_n = 1; bus_ad_in = addr;
    bus_tick(s, o);
    bus_adv_n = 1;
    bus_tick(s, o);
    bus_ad_in = 16'h1111;
    bus_tick(s, o);
    bus_cs_n = 1;
    bus_tick(s, o);
    bus_tick(s, o);
    chk("R7 aborted write no strobe", wr_cnt, w0);
  endtask

  task automatic do_abort_read(input logic [15:0] addr);
    logic [15:0] s; logic o;
    bus_cs_n = 0; bus_adv_n = 0; bus_rw = 1; bus_oe_n = 1; bus_ad_in = addr;
    bus_tick(s, o);
    bus_adv_n = 1; bus_oe_n = 0;
    bus_tick(s, o);
    bus_tick(s, o);
    bus_cs_n = 1;
    #1;
    chk("R7 aborted read releases lines", {31'd0, bus_ad_oe}, 32'd0);
    bus_oe_n = 1;
    bus_tick(s, o);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 enable low after reset", {31'd0, bus_ad_oe}, 32'd0);
    chk("R1 no write strobe", wr_cnt, 0);
    chk("R1 no read request", rd_cnt, 0);
    do_write(16'h0010, 32'hA5A5_1234);
    do_write(16'h0011, 32'h0000_FFFF);   // odd address, same word
    do_write(16'hFFFE, 32'h8001_7FFE);
    do_read(16'h0040);
    do_read(16'h7FFF);
    do_abort_write(16'h0020);
    do_write(16'h0022, 32'h5A5A_C3C3);   // R7: next access after abort
    do_abort_read(16'h0030);
    do_read(16'h0032);                   // R7: read after aborted read
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule